// File: doc/BRIEF.md
# Break and Memory-Protection Comparator Unit

The unit holds a parameterised number of comparator groups (eight by default). Each group owns two inclusive address/value range comparators. A per-group source code routes each comparator to the instruction-fetch address, the operand address or the operand data value. With protection disabled, the unit is a debug breakpoint engine. Groups raise instruction, operand-address and data-value breaks. Each group records the cause in sticky status flags that software clears by writing a mask. A combine bit pairs the two comparators of a group into a single data-value break, which fires only when the operand address and its data match in the same access.

With protection enabled, the same ranges carry permissions instead of break conditions. Instruction-sourced ranges carry an execute right, and operand-sourced ranges carry read and write rights. Each right is held twice, once for user mode and once for supervisor mode, and the privilege input picks which set is checked. An access that lands in an enabled range without the needed right produces a one-cycle violation pulse.

The unit is configured through a plain address/data write port. A write changes behaviour from the following cycle. Break and violation outputs are registered, so each one follows its access by one clock.

Top module: `bmp_unit`

## Requirements
- R1: After reset, brk_o, viol_o and every status flag are 0, protection is off, and every comparator is disabled.
- R2: A comparator hits when lo <= value <= hi. Both bounds are inclusive and compared unsigned, and the source valid must be high.
- R3: The group source code (cfg bits [1:0]) wires the comparators as follows. 00 puts both on the fetch address. 01 puts both on the operand address. 10 puts comparator 0 on the fetch address and comparator 1 on the operand address. 11 puts comparator 0 on the operand data and comparator 1 on the operand address.
- R4: With combine (cfg bit 2) at 0 and protection off, each enabled comparator (enable 0 = cfg bit 3, enable 1 = cfg bit 4) that hits breaks on its own. Status bit k of its group is set. Status bit k+2 is also set when comparator k watches the operand address or data. brk_o is high in the cycle after the access.
- R5: With combine at 1 and protection off, a group breaks only when the source code is 11, both enables are on, and both comparators hit in the same access. Such a break sets all four status bits of the group. Any other setting detects nothing.
- R6: Status flags stay set until a write to group word 5 clears the bits given by wr_data_i[3:0]. Bits outside the mask are unchanged.
- R7: Breaks from several groups in one access merge into a single brk_o pulse, and every group that hit sets its own flags.
- R8: Word 0 of group index NUM_GRP, bit 0, turns protection on. While protection is on, no break is raised and no status flag changes. A fetch inside an enabled fetch-sourced range without the execute right (bit 2 of a 3-bit right field) gives a viol_o pulse one cycle later.
- R9: In operand-sourced ranges, a read (op_kind_i 00) needs right bit 0 and a write (01) needs right bit 1. A read-modify-write (1x) needs both. Data-sourced comparators do no protection checking.
- R10: priv_i = 1 selects the supervisor rights, and priv_i = 0 selects the user rights. Comparator 0 uses user rights in cfg [7:5] and supervisor rights in [10:8]. Comparator 1 uses user rights in [13:11] and supervisor rights in [16:14].
- R11: An access outside every enabled range never causes a violation.
- R12: Per-group word map: 0 cfg, 1 lo0, 2 hi0, 3 lo1, 4 hi1, 5 status clear, addressed as {group, word}. A write changes behaviour for accesses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | clog2(NUM_GRP+1)+3 | Register address {group, word} |
| wr_data_i | input | XLEN | Register write data |
| if_valid_i | input | 1 | Instruction fetch valid |
| if_addr_i | input | XLEN | Instruction fetch address |
| op_valid_i | input | 1 | Operand access valid |
| op_addr_i | input | XLEN | Operand address |
| op_data_i | input | XLEN | Operand data value |
| op_kind_i | input | 2 | 00 read, 01 write, 1x read-modify-write |
| priv_i | input | 1 | 1 supervisor, 0 user |
| brk_o | output | 1 | Break request, one cycle after the access |
| viol_o | output | 1 | Protection violation pulse, one cycle after the access |
| sts_o | output | 4*NUM_GRP | Sticky break flags, four per group |

## Verification
A corrupted bound, source code or right bit shows at the ports one clock after the first access that tests it. It appears as a missing or spurious brk_o or viol_o pulse. A wrong status update is more persistent, because the flags are sticky. A flag set wrongly or cleared wrongly stays visible on sts_o in every later comparison until the next clear write. Each access in the bench is therefore checked against the expected value of all three outputs together. Accesses placed exactly on lo, on hi and one step outside expose errors in the comparator boundaries.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  localparam int unsigned OFS_W   = 3;
  localparam int unsigned NUM_OFS = 6;
  localparam int unsigned STS_W   = 4;
  localparam int unsigned CFG_W   = 17;

  localparam int unsigned OFS_CFG  = 0;
  localparam int unsigned OFS_LO0  = 1;
  localparam int unsigned OFS_HI0  = 2;
  localparam int unsigned OFS_CLR  = 5;
  localparam int unsigned OFS_CTRL = 0;

  typedef enum logic [1:0] {
    SRC_II = 2'b00,
    SRC_OO = 2'b01,
    SRC_IO = 2'b10,
    SRC_DO = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    KND_INS = 2'd0,
    KND_OPA = 2'd1,
    KND_DAT = 2'd2
  } cmp_kind_e;

  // right field: [0] read, [1] write, [2] execute
  typedef struct packed {
    logic [2:0] sup1;
    logic [2:0] usr1;
    logic [2:0] sup0;
    logic [2:0] usr0;
    logic       en1;
    logic       en0;
    logic       comb;
    src_sel_e   src;
  } grp_cfg_t;
endpackage

// File: rtl/bmp_range_cmp.sv
module bmp_range_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] hi_i,
  output logic            hit_o
);
  assign hit_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/bmp_group.sv
module bmp_group import bmp_pkg::*; #(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OFS-1:0] wr_sel_i,
  input  logic [XLEN-1:0]    wr_data_i,
  input  logic               prot_en_i,
  input  logic               if_valid_i,
  input  logic [XLEN-1:0]    if_addr_i,
  input  logic               op_valid_i,
  input  logic [XLEN-1:0]    op_addr_i,
  input  logic [XLEN-1:0]    op_data_i,
  input  logic [1:0]         op_kind_i,
  input  logic               priv_i,
  output logic               brk_o,
  output logic               viol_o,
  output logic [STS_W-1:0]   sts_o
);
  grp_cfg_t               cfg_q;
  logic [STS_W-1:0]       sts_q, set_d, clr_m;
  cmp_kind_e              knd [2];
  logic [1:0][XLEN-1:0]   val;
  logic [1:0]             act, in_rng, en, match, granted;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cfg_q <= '0;
    else if (wr_sel_i[OFS_CFG]) cfg_q <= grp_cfg_t'(wr_data_i[CFG_W-1:0]);

  assign en = {cfg_q.en1, cfg_q.en0};

  always_comb begin
    knd[0] = (cfg_q.src == SRC_DO) ? KND_DAT :
             (cfg_q.src == SRC_OO) ? KND_OPA : KND_INS;
    knd[1] = (cfg_q.src == SRC_II) ? KND_INS : KND_OPA;
    for (int k = 0; k < 2; k++) begin
      unique case (knd[k])
        KND_INS: begin val[k] = if_addr_i; act[k] = if_valid_i; end
        KND_OPA: begin val[k] = op_addr_i; act[k] = op_valid_i; end
        default: begin val[k] = op_data_i; act[k] = op_valid_i; end
      endcase
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_cmp
    logic [XLEN-1:0] lo_q, hi_q;
    logic [2:0]      rights;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (wr_sel_i[OFS_LO0 + 2*k]) lo_q <= wr_data_i;
        if (wr_sel_i[OFS_HI0 + 2*k]) hi_q <= wr_data_i;
      end

    bmp_range_cmp #(.XLEN(XLEN)) u_rng (
      .val_i (val[k]),
      .lo_i  (lo_q),
      .hi_i  (hi_q),
      .hit_o (in_rng[k])
    );

    if (k == 0) begin : g_r0
      assign rights = priv_i ? cfg_q.sup0 : cfg_q.usr0;
    end else begin : g_r1
      assign rights = priv_i ? cfg_q.sup1 : cfg_q.usr1;
    end

    always_comb begin
      if (knd[k] == KND_INS)   granted[k] = rights[2];
      else if (op_kind_i[1])   granted[k] = rights[0] & rights[1];
      else if (op_kind_i[0])   granted[k] = rights[1];
      else                     granted[k] = rights[0];
    end

    assign match[k] = en[k] & in_rng[k] & act[k];
  end

  always_comb begin
    set_d  = '0;
    brk_o  = 1'b0;
    viol_o = 1'b0;
    if (!prot_en_i) begin
      if (cfg_q.comb) begin
        if (cfg_q.src == SRC_DO && &match) begin
          set_d = '1;
          brk_o = 1'b1;
        end
      end else begin
        for (int k = 0; k < 2; k++)
          if (match[k]) begin
            brk_o      = 1'b1;
            set_d[k]   = 1'b1;
            set_d[k+2] = (knd[k] != KND_INS);
          end
      end
    end else begin
      for (int k = 0; k < 2; k++)
        if (match[k] && knd[k] != KND_DAT && !granted[k]) viol_o = 1'b1;
    end
  end

  assign clr_m = {STS_W{wr_sel_i[OFS_CLR]}} & wr_data_i[STS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_m) | set_d;

  assign sts_o = sts_q;
endmodule

// File: rtl/bmp_unit.sv
module bmp_unit import bmp_pkg::*; #(
  parameter  int unsigned NUM_GRP = 8,
  parameter  int unsigned XLEN    = 32,
  localparam int unsigned GRP_W   = $clog2(NUM_GRP + 1),
  localparam int unsigned ADDR_W  = GRP_W + OFS_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [XLEN-1:0]          wr_data_i,
  input  logic                     if_valid_i,
  input  logic [XLEN-1:0]          if_addr_i,
  input  logic                     op_valid_i,
  input  logic [XLEN-1:0]          op_addr_i,
  input  logic [XLEN-1:0]          op_data_i,
  input  logic [1:0]               op_kind_i,
  input  logic                     priv_i,
  output logic                     brk_o,
  output logic                     viol_o,
  output logic [STS_W*NUM_GRP-1:0] sts_o
);
  logic [GRP_W-1:0]                 wr_grp;
  logic [OFS_W-1:0]                 wr_ofs;
  logic [NUM_GRP-1:0][NUM_OFS-1:0]  wr_sel;
  logic [NUM_GRP-1:0]               grp_brk, grp_viol;
  logic                             prot_en_q, brk_q, viol_q;

  assign wr_grp = wr_addr_i[ADDR_W-1:OFS_W];
  assign wr_ofs = wr_addr_i[OFS_W-1:0];

  always_comb
    for (int g = 0; g < NUM_GRP; g++)
      for (int o = 0; o < NUM_OFS; o++)
        wr_sel[g][o] = wr_en_i && (wr_grp == GRP_W'(g)) && (wr_ofs == OFS_W'(o));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prot_en_q <= 1'b0;
    else if (wr_en_i && wr_grp == GRP_W'(NUM_GRP) && wr_ofs == OFS_W'(OFS_CTRL))
      prot_en_q <= wr_data_i[0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    bmp_group #(.XLEN(XLEN)) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_sel_i   (wr_sel[g]),
      .wr_data_i  (wr_data_i),
      .prot_en_i  (prot_en_q),
      .if_valid_i (if_valid_i),
      .if_addr_i  (if_addr_i),
      .op_valid_i (op_valid_i),
      .op_addr_i  (op_addr_i),
      .op_data_i  (op_data_i),
      .op_kind_i  (op_kind_i),
      .priv_i     (priv_i),
      .brk_o      (grp_brk[g]),
      .viol_o     (grp_viol[g]),
      .sts_o      (sts_o[g*STS_W +: STS_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      brk_q  <= |grp_brk;
      viol_q <= |grp_viol;
    end

  assign brk_o  = brk_q;
  assign viol_o = viol_q;
endmodule

// File: rtl/bmp_unit_chk.sv
module bmp_unit_chk #(
  parameter int unsigned NUM_GRP = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 if_valid_i,
  input logic                 op_valid_i,
  input logic                 prot_en_q,
  input logic                 brk_o,
  input logic                 viol_o,
  input logic [4*NUM_GRP-1:0] sts_o
);
  // R8
  brk_viol_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brk_o && viol_o));

  // R8
  prot_no_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_en_q |=> !brk_o);

  // R8
  prot_sts_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_en_q && !wr_en_i) |=> (sts_o == $past(sts_o)));

  // R6
  sts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

  // R4
  brk_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past(if_valid_i || op_valid_i));

  // R4
  brk_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (sts_o != '0));

  // R8
  viol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(if_valid_i || op_valid_i));
endmodule

bind bmp_unit bmp_unit_chk #(.NUM_GRP(NUM_GRP)) u_chk (.*);

// File: tb/tb_bmp_unit.sv
`timescale 1ns/1ps
module tb_bmp_unit;
  localparam int NG = 8;
  localparam int AW = 7;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic          if_valid_i = 1'b0;
  logic [31:0]   if_addr_i = '0;
  logic          op_valid_i = 1'b0;
  logic [31:0]   op_addr_i = '0;
  logic [31:0]   op_data_i = '0;
  logic [1:0]    op_kind_i = '0;
  logic          priv_i = 1'b0;
  logic          brk_o, viol_o;
  logic [4*NG-1:0] sts_o;

  int checks = 0;
  int errors = 0;

  logic [33:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] cfg_m [NG];
  logic [31:0] lo_m  [NG][2];
  logic [31:0] hi_m  [NG][2];
  logic [4*NG-1:0] sts_m = '0;
  bit prot_m = 1'b0;

  always #10 clk_i = ~clk_i;

  bmp_unit #(.NUM_GRP(NG), .XLEN(32)) dut (.*);

  function automatic logic [AW-1:0] ra(int g, int o);
    return {4'(g), 3'(o)};
  endfunction

  function automatic logic [31:0] mk_cfg(logic [1:0] src, bit comb, bit e0, bit e1,
                                         logic [2:0] u0, logic [2:0] s0,
                                         logic [2:0] u1, logic [2:0] s1);
    return {15'd0, s1, u1, s0, u0, e1, e0, comb, src};
  endfunction

  task automatic wr(int g, int o, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = ra(g, o); wr_data_i = d;
    if (g == NG) prot_m = d[0];
    else case (o)
      0: cfg_m[g] = d;
      1: lo_m[g][0] = d;
      2: hi_m[g][0] = d;
      3: lo_m[g][1] = d;
      4: hi_m[g][1] = d;
      5: sts_m[g*4 +: 4] = sts_m[g*4 +: 4] & ~d[3:0];
      default: ;
    endcase
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // requirement model for one access; updates sts_m
  task automatic model(bit ifv, logic [31:0] ia, bit opv, logic [31:0] oa,
                       logic [31:0] od, logic [1:0] kind, bit priv,
                       output bit eb, output bit ev);
    eb = 0; ev = 0;
    for (int g = 0; g < NG; g++) begin
      logic [31:0] c;
      int kd [2];
      logic [31:0] v [2];
      bit a [2];
      bit h [2];
      logic [2:0] rt;
      bit need;
      c = cfg_m[g];
      case (c[1:0])
        2'b00: begin kd[0] = 0; kd[1] = 0; end
        2'b01: begin kd[0] = 1; kd[1] = 1; end
        2'b10: begin kd[0] = 0; kd[1] = 1; end
        default: begin kd[0] = 2; kd[1] = 1; end
      endcase
      for (int k = 0; k < 2; k++) begin
        v[k] = (kd[k] == 0) ? ia : (kd[k] == 1) ? oa : od;
        a[k] = (kd[k] == 0) ? ifv : opv;
        h[k] = c[3+k] && a[k] && v[k] >= lo_m[g][k] && v[k] <= hi_m[g][k];
      end
      if (!prot_m) begin
        if (c[2]) begin
          if (c[1:0] == 2'b11 && h[0] && h[1]) begin eb = 1; sts_m[g*4 +: 4] = 4'hF; end
        end else begin
          for (int k = 0; k < 2; k++) if (h[k]) begin
            eb = 1; sts_m[g*4 + k] = 1'b1;
            if (kd[k] != 0) sts_m[g*4 + k + 2] = 1'b1;
          end
        end
      end else begin
        for (int k = 0; k < 2; k++) if (h[k] && kd[k] != 2) begin
          rt = priv ? (k == 1 ? c[16:14] : c[10:8]) : (k == 1 ? c[13:11] : c[7:5]);
          if (kd[k] == 0)   need = rt[2];
          else if (kind[1]) need = rt[0] & rt[1];
          else if (kind[0]) need = rt[1];
          else              need = rt[0];
          if (!need) ev = 1;
        end
      end
    end
  endtask

  // driver: one access, expected result pushed to the scoreboard
  task automatic acc(string tag, bit ifv, logic [31:0] ia, bit opv, logic [31:0] oa,
                     logic [31:0] od, logic [1:0] kind, bit priv);
    bit eb, ev;
    @(negedge clk_i);
    if_valid_i = ifv; if_addr_i = ia; op_valid_i = opv; op_addr_i = oa;
    op_data_i = od; op_kind_i = kind; priv_i = priv;
    model(ifv, ia, opv, oa, od, kind, priv, eb, ev);
    exp_q.push_back({eb, ev, sts_m});
    tag_q.push_back(tag);
    @(negedge clk_i);
    if_valid_i = 1'b0; op_valid_i = 1'b0;
  endtask

  // monitor: compare registered outputs against queued expectations
  initial forever begin
    @(posedge clk_i);
    #5;
    if (exp_q.size() != 0) begin
      logic [33:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({brk_o, viol_o, sts_o} !== e) begin
        errors++;
        $display("FAIL %s brk/viol/sts got %b/%b/%h exp %b/%b/%h",
                 t, brk_o, viol_o, sts_o, e[33], e[32], e[31:0]);
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      cfg_m[g] = '0;
      for (int k = 0; k < 2; k++) begin lo_m[g][k] = '0; hi_m[g][k] = '0; end
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if ({brk_o, viol_o, sts_o} !== '0) begin
      errors++;
      $display("FAIL R1 reset got %b/%b/%h exp 0/0/0", brk_o, viol_o, sts_o);
    end
    acc("R1 disabled comparators", 1, 32'h0, 1, 32'h0, 32'h0, 2'b00, 0);

    // R12 R3 R2: group 0 fetch range, inclusive edges
    wr(0, 1, 32'h1000); wr(0, 2, 32'h10FF);
    wr(0, 0, mk_cfg(2'b00, 0, 1, 0, 0, 0, 0, 0));
    acc("R2 low edge", 1, 32'h1000, 0, 0, 0, 2'b00, 0);
    acc("R2 high edge", 1, 32'h10FF, 0, 0, 0, 2'b00, 0);
    acc("R2 above", 1, 32'h1100, 0, 0, 0, 2'b00, 0);
    acc("R2 below", 1, 32'h0FFF, 0, 0, 0, 2'b00, 0);
    acc("R3 operand ignored by fetch range", 0, 0, 1, 32'h1000, 0, 2'b00, 0);
    wr(0, 5, 32'h1);
    acc("R6 cleared", 1, 32'h2000, 0, 0, 0, 2'b00, 0);

    // R4 R3: group 1 operand-address comparator 1
    wr(1, 3, 32'h2000); wr(1, 4, 32'h2FFF);
    wr(1, 0, mk_cfg(2'b01, 0, 0, 1, 0, 0, 0, 0));
    acc("R4 operand break", 0, 0, 1, 32'h2800, 0, 2'b01, 0);
    acc("R3 fetch not seen", 1, 32'h2800, 0, 0, 0, 2'b00, 0);
    acc("R6 sticky", 0, 0, 1, 32'h9000, 0, 2'b00, 0);
    wr(1, 5, 32'h2);
    acc("R6 partial clear", 0, 0, 0, 0, 0, 2'b00, 0);
    wr(1, 5, 32'hF);

    // R3 type 10: fetch on 0, operand on 1
    wr(2, 1, 32'h3000); wr(2, 2, 32'h3000); wr(2, 3, 32'h4000); wr(2, 4, 32'h4010);
    wr(2, 0, mk_cfg(2'b10, 0, 1, 1, 0, 0, 0, 0));
    acc("R3 mixed source", 1, 32'h3000, 1, 32'h4010, 0, 2'b00, 0);
    wr(2, 0, 32'h0); wr(2, 5, 32'hF);

    // R4 type 11 independent data break
    wr(3, 1, 32'hAA); wr(3, 2, 32'hAA); wr(3, 3, 32'h5000); wr(3, 4, 32'h50FF);
    wr(3, 0, mk_cfg(2'b11, 0, 1, 0, 0, 0, 0, 0));
    acc("R4 data break", 0, 0, 1, 32'h7000, 32'hAA, 2'b00, 0);
    wr(3, 5, 32'hF);

    // R5 combined data-value break
    wr(3, 0, mk_cfg(2'b11, 1, 1, 1, 0, 0, 0, 0));
    acc("R5 data only", 0, 0, 1, 32'h6000, 32'hAA, 2'b00, 0);
    acc("R5 address only", 0, 0, 1, 32'h5010, 32'hAB, 2'b00, 0);
    acc("R5 both match", 0, 0, 1, 32'h5010, 32'hAA, 2'b01, 0);
    wr(3, 5, 32'hF);
    wr(3, 0, mk_cfg(2'b11, 1, 0, 1, 0, 0, 0, 0));
    acc("R5 single enable", 0, 0, 1, 32'h5010, 32'hAA, 2'b00, 0);
    wr(3, 0, mk_cfg(2'b01, 1, 1, 1, 0, 0, 0, 0));
    acc("R5 combine wrong type", 0, 0, 1, 32'h5010, 32'hAA, 2'b00, 0);

    // R7 two groups in one access
    acc("R7 merged break", 1, 32'h1004, 1, 32'h2004, 0, 2'b00, 0);
    wr(0, 5, 32'hF); wr(1, 5, 32'hF);

    // protection setup
    wr(0, 0, mk_cfg(2'b00, 0, 1, 0, 3'b000, 3'b100, 0, 0));
    wr(1, 0, mk_cfg(2'b01, 0, 0, 1, 0, 0, 3'b001, 3'b011));
    wr(3, 0, mk_cfg(2'b11, 0, 1, 1, 0, 0, 3'b011, 3'b011));
    wr(NG, 0, 32'h1);
    acc("R8 exec denied user", 1, 32'h1000, 0, 0, 0, 2'b00, 0);
    acc("R10 exec granted supervisor", 1, 32'h1000, 0, 0, 0, 2'b00, 1);
    acc("R11 fetch outside ranges", 1, 32'h2000, 0, 0, 0, 2'b00, 0);
    acc("R9 read granted", 0, 0, 1, 32'h2800, 0, 2'b00, 0);
    acc("R9 write denied user", 0, 0, 1, 32'h2800, 0, 2'b01, 0);
    acc("R10 write granted supervisor", 0, 0, 1, 32'h2800, 0, 2'b01, 1);
    acc("R9 rmw denied read-only", 0, 0, 1, 32'h2800, 0, 2'b10, 0);
    acc("R9 rmw granted rw", 0, 0, 1, 32'h2800, 0, 2'b10, 1);
    acc("R9 data comparator unchecked", 0, 0, 1, 32'h5010, 32'hAA, 2'b11, 0);
    acc("R11 operand outside", 0, 0, 1, 32'h7000, 32'hAA, 2'b01, 0);

    // R12 protection off again restores breaks
    wr(NG, 0, 32'h0);
    acc("R12 break after mode change", 1, 32'h1000, 0, 0, 0, 2'b00, 0);

    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule